// File: doc/BRIEF.md
# UTF-32 to UTF-8 Store Encoder

This block takes one 32-bit Unicode scalar value per cycle and turns it into its UTF-8 byte sequence. The bytes come out packed little-end-first into a 32-bit word. Alongside the bytes it gives the sequence length in bytes and a 4-bit byte-enable mask. A store unit with per-byte write enables can take the word and mask as they are and write exactly the bytes that belong to the character. The caller advances its pointer by the length.

Values that are not Unicode scalar values raise an error flag and produce an empty result. These are the surrogate range 0xD800..0xDFFF and anything above 0x10FFFF, including values with any of bits 31..21 set. An empty result has length 0, a zero mask and zero bytes.

The encoding logic is purely combinational. It is followed by a single output register, so the result appears one cycle after the input. A new code point can be accepted every cycle.

Top module: `utf8_store_encoder`

## Requirements
- R1: While the synchronous active-low reset is held, every output (valid, bytes, length, mask, error) is zero on the clock edge that follows.
- R2: The output valid equals the input valid of the previous cycle. A code point presented with valid high is reflected on the outputs one cycle later. After a cycle with valid low, all outputs are zero.
- R3: The length is 1 for values 0x0..0x7F, 2 for 0x80..0x7FF, 3 for 0x800..0xFFFF excluding surrogates, and 4 for 0x10000..0x10FFFF.
- R4: A 1-byte result carries the code point itself in bits [7:0].
- R5: A 2-byte result has the lead byte 0xC0 | cp[10:6] in bits [7:0] and the continuation byte 0x80 | cp[5:0] in bits [15:8].
- R6: A 3-byte result has bits [7:0] = 0xE0 | cp[15:12], bits [15:8] = 0x80 | cp[11:6] and bits [23:16] = 0x80 | cp[5:0].
- R7: A 4-byte result has bits [7:0] = 0xF0 | cp[20:18], bits [15:8] = 0x80 | cp[17:12], bits [23:16] = 0x80 | cp[11:6] and bits [31:24] = 0x80 | cp[5:0].
- R8: Bytes at positions at or above the length are zero.
- R9: Mask bit k is 1 exactly when k is below the length, giving 4'b0001, 4'b0011, 4'b0111 or 4'b1111 for lengths 1 to 4.
- R10: A value in 0xD800..0xDFFF sets the error flag. The length, mask and bytes are then zero.
- R11: A value above 0x10FFFF sets the error flag in the same way. This includes values with any of bits 31..21 set.
- R12: Code points presented on consecutive cycles each produce their own correct result on consecutive cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cp_valid_i | input | 1 | Code point on cp_i is to be encoded |
| cp_i | input | 32 | UTF-32 code point |
| out_valid_o | output | 1 | Registered result is present |
| out_bytes_o | output | 32 | Encoded bytes, first byte in bits [7:0] |
| out_len_o | output | 3 | Number of valid bytes, 0..4 |
| out_be_o | output | 4 | Byte-enable mask, low `length` bits set |
| out_err_o | output | 1 | Input was a surrogate or above 0x10FFFF |

## Verification
The hard cases are the edges between length classes and the two ends of the surrogate gap. One value either side of each of these edges changes the length, the lead-byte prefix and the mask together. The bench therefore walks every value from 0 to 0x7FF one by one. It then strides through the 3- and 4-byte ranges and adds every edge value and its neighbours explicitly. This places 0x7FF/0x800, 0xD7FF/0xD800, 0xDFFF/0xE000, 0xFFFF/0x10000 and 0x10FFFF/0x110000 back to back on consecutive cycles. Values with high bits set, such as 0x80000041, verify that bits 31..21 are not silently dropped.

// File: rtl/utf8enc_pkg.sv
// Package: shared widths and Unicode range limits for the UTF-8 store encoder.
// Assumes 8-bit bytes and at most four bytes per encoded character.
package utf8enc_pkg;
    localparam int CP_W      = 32;              // width of a UTF-32 code point word
    localparam int MAX_BYTES = 4;               // longest UTF-8 sequence
    localparam int BYTES_W   = 8 * MAX_BYTES;   // packed output word
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);

    // Upper bounds of each length class and of the surrogate gap.
    localparam logic [CP_W-1:0] LIM_ONE   = 32'h0000_007F;
    localparam logic [CP_W-1:0] LIM_TWO   = 32'h0000_07FF;
    localparam logic [CP_W-1:0] LIM_THREE = 32'h0000_FFFF;
    localparam logic [CP_W-1:0] LIM_FOUR  = 32'h0010_FFFF;
    localparam logic [CP_W-1:0] SUR_LO    = 32'h0000_D800;
    localparam logic [CP_W-1:0] SUR_HI    = 32'h0000_DFFF;

    // Classification result for one code point.
    typedef struct packed {
        logic             bad;
        logic [LEN_W-1:0] len;
    } cp_class_t;
endpackage

// File: rtl/utf8_cp_classify.sv
// Module: decides how many UTF-8 bytes a code point needs, or flags it as
// not a Unicode scalar value. Purely combinational; assumes nothing about
// the input range (any 32-bit value is accepted).
module utf8_cp_classify
    import utf8enc_pkg::*;
(
    input  logic [CP_W-1:0] cp_i,
    output cp_class_t       cls_o
);
    logic in_gap;
    logic too_big;

    // Out-of-range detection: surrogate gap and beyond the last plane.
    always_comb begin
        in_gap  = (cp_i >= SUR_LO) && (cp_i <= SUR_HI);
        too_big = (cp_i > LIM_FOUR);
    end

    // Length selection; an illegal value gets length zero.
    always_comb begin
        cls_o.bad = in_gap || too_big;
        if (cls_o.bad)             cls_o.len = LEN_W'(0);
        else if (cp_i <= LIM_ONE)  cls_o.len = LEN_W'(1);
        else if (cp_i <= LIM_TWO)  cls_o.len = LEN_W'(2);
        else if (cp_i <= LIM_THREE) cls_o.len = LEN_W'(3);
        else                       cls_o.len = LEN_W'(4);
    end
endmodule

// File: rtl/utf8_byte_pack.sv
// Module: builds the packed UTF-8 byte word from a code point and its length.
// Lane k holds the k-th byte of the sequence; lanes at or above the length,
// and all lanes of an illegal value, are zero. Assumes len_i came from
// utf8_cp_classify for the same cp_i.
module utf8_byte_pack
    import utf8enc_pkg::*;
(
    input  logic [CP_W-1:0]    cp_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               bad_i,
    output logic [BYTES_W-1:0] bytes_o
);
    localparam int SH_W = 5;   // holds 6*(MAX_BYTES-1) = 18

    logic [7:0] lead_prefix;
    logic [7:0] lead_keep;

    // Lead byte framing: prefix has len ones at the top, payload is below a zero.
    always_comb begin
        lead_prefix = ~(8'hFF >> len_i);
        lead_keep   = 8'hFF >> (len_i + LEN_W'(1));
    end

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
        logic [SH_W-1:0] shamt;
        logic [CP_W-1:0] shifted;
        logic [7:0]      lane;

        // Shift so this lane's 6 payload bits land at the bottom.
        always_comb begin
            if (int'(len_i) > k)
                shamt = SH_W'(6 * (int'(len_i) - 1 - k));
            else
                shamt = '0;
            shifted = cp_i >> shamt;
        end

        // Form the byte for this lane: plain, lead or continuation.
        always_comb begin
            lane = 8'h00;
            if (!bad_i && (int'(len_i) > k)) begin
                if (k == 0 && len_i == LEN_W'(1))
                    lane = cp_i[7:0];
                else if (k == 0)
                    lane = lead_prefix | (shifted[7:0] & lead_keep);
                else
                    lane = {2'b10, shifted[5:0]};
            end
        end

        assign bytes_o[8*k +: 8] = lane;
    end
endmodule

// File: rtl/utf8_lane_mask.sv
// Module: turns a byte count into a byte-enable mask with the low `count`
// bits set. Assumes len_i never exceeds MAX_BYTES.
module utf8_lane_mask
    import utf8enc_pkg::*;
(
    input  logic [LEN_W-1:0]     len_i,
    output logic [MAX_BYTES-1:0] be_o
);
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_bit
        // Lane k is written when it lies below the length.
        assign be_o[k] = (int'(len_i) > k);
    end
endmodule

// File: rtl/utf8_store_encoder.sv
// Module: top of the UTF-32 to UTF-8 encoder. Classifies the code point,
// packs its bytes, derives the store mask and registers everything once,
// giving one cycle of latency and one result per cycle. Outputs are zero
// whenever no result is present. Synchronous active-low reset.
module utf8_store_encoder
    import utf8enc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cp_valid_i,
    input  logic [CP_W-1:0]      cp_i,
    output logic                 out_valid_o,
    output logic [BYTES_W-1:0]   out_bytes_o,
    output logic [LEN_W-1:0]     out_len_o,
    output logic [MAX_BYTES-1:0] out_be_o,
    output logic                 out_err_o
);
    cp_class_t            cls;
    logic [BYTES_W-1:0]   bytes_d;
    logic [MAX_BYTES-1:0] be_d;

    utf8_cp_classify u_classify (
        .cp_i  (cp_i),
        .cls_o (cls)
    );

    utf8_byte_pack u_pack (
        .cp_i    (cp_i),
        .len_i   (cls.len),
        .bad_i   (cls.bad),
        .bytes_o (bytes_d)
    );

    utf8_lane_mask u_mask (
        .len_i (cls.len),
        .be_o  (be_d)
    );

    // Output stage: capture a result when valid, otherwise clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_bytes_o <= '0;
            out_len_o   <= '0;
            out_be_o    <= '0;
            out_err_o   <= 1'b0;
        end else begin
            out_valid_o <= cp_valid_i;
            if (cp_valid_i) begin
                out_bytes_o <= bytes_d;
                out_len_o   <= cls.len;
                out_be_o    <= be_d;
                out_err_o   <= cls.bad;
            end else begin
                out_bytes_o <= '0;
                out_len_o   <= '0;
                out_be_o    <= '0;
                out_err_o   <= 1'b0;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid_i |=> out_valid_o); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_valid_i |=> !out_valid_o); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_bytes_o == '0 && out_len_o == '0 && out_be_o == '0 && !out_err_o)); // R2
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_err_o) |-> (out_len_o >= LEN_W'(1) && out_len_o <= LEN_W'(MAX_BYTES))); // R3
    AST_ASCII_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_len_o == LEN_W'(1)) |-> !out_bytes_o[7]); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_len_o == LEN_W'(2)) |-> (out_bytes_o[BYTES_W-1:16] == '0)); // R8
    AST_MASK_MATCHES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ($countones(out_be_o) == int'(out_len_o) && out_be_o[0] == (out_len_o != '0))); // R9
    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_err_o |-> (out_len_o == '0 && out_be_o == '0 && out_bytes_o == '0)); // R10
    AST_CONT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_len_o == LEN_W'(4)) |-> (out_bytes_o[31:30] == 2'b10 && out_bytes_o[7:3] == 5'b11110)); // R7
endmodule

// File: tb/utf8_store_encoder_bench.sv
// Bench: sweeps code points through the encoder back to back and compares
// every output against values computed arithmetically here.
module utf8_store_encoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_valid_i = 1'b0;
    logic [31:0] cp_i = '0;
    logic        out_valid_o;
    logic [31:0] out_bytes_o;
    logic [2:0]  out_len_o;
    logic [3:0]  out_be_o;
    logic        out_err_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    utf8_store_encoder u_utf8_store_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cp_valid_i  (cp_valid_i),
        .cp_i        (cp_i),
        .out_valid_o (out_valid_o),
        .out_bytes_o (out_bytes_o),
        .out_len_o   (out_len_o),
        .out_be_o    (out_be_o),
        .out_err_o   (out_err_o)
    );

    function automatic logic is_bad(input logic [31:0] v);
        return (v > 32'h10FFFF) || (v >= 32'hD800 && v <= 32'hDFFF);
    endfunction

    function automatic logic [2:0] exp_len(input logic [31:0] v);
        if (is_bad(v))        return 3'd0;
        else if (v < 32'h80)  return 3'd1;
        else if (v < 32'h800) return 3'd2;
        else if (v < 32'h10000) return 3'd3;
        else                  return 3'd4;
    endfunction

    function automatic logic [31:0] exp_bytes(input logic [31:0] v);
        case (exp_len(v))
            3'd1: return {24'h0, v[7:0]};
            3'd2: return {16'h0, 2'b10, v[5:0], 3'b110, v[10:6]};
            3'd3: return {8'h0, 2'b10, v[5:0], 2'b10, v[11:6], 4'b1110, v[15:12]};
            3'd4: return {2'b10, v[5:0], 2'b10, v[11:6], 2'b10, v[17:12], 5'b11110, v[20:18]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(input logic [2:0] n);
        return 4'((5'd1 << n) - 5'd1);
    endfunction

    function automatic string tag_of(input logic [31:0] v);
        if (v > 32'h10FFFF) return "R11";
        if (is_bad(v))      return "R10";
        case (exp_len(v))
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_result(input logic [31:0] v, input string tag);
        logic [2:0]  el;
        logic [31:0] eb;
        logic [3:0]  em;
        logic        ee;
        el = exp_len(v);
        eb = exp_bytes(v);
        em = exp_be(el);
        ee = is_bad(v);
        total++;
        if (out_valid_o !== 1'b1 || out_bytes_o !== eb || out_len_o !== el ||
            out_be_o !== em || out_err_o !== ee) begin
            bad++;
            $display("FAIL %s/R3/R8/R9/R12 cp=%h: got v=%b bytes=%h len=%0d be=%b err=%b exp v=1 bytes=%h len=%0d be=%b err=%b",
                     tag, v, out_valid_o, out_bytes_o, out_len_o, out_be_o, out_err_o, eb, el, em, ee);
        end
    endtask

    task automatic check_quiet(input string tag);
        total++;
        if (out_valid_o !== 1'b0 || out_bytes_o !== '0 || out_len_o !== '0 ||
            out_be_o !== '0 || out_err_o !== 1'b0) begin
            bad++;
            $display("FAIL %s quiet outputs: got v=%b bytes=%h len=%0d be=%b err=%b exp all zero",
                     tag, out_valid_o, out_bytes_o, out_len_o, out_be_o, out_err_o);
        end
    endtask

    // Drive one code point; its result is checked at the next falling edge.
    task automatic push(input logic [31:0] v);
        cp_i = v;
        cp_valid_i = 1'b1;
        @(negedge clk);
        check_result(v, tag_of(v));
    endtask

    task automatic idle_cycle();
        cp_valid_i = 1'b0;
        cp_i = 32'h0000_00E9;
        @(negedge clk);
        check_quiet("R2");
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] edges [0:17];
        edges = '{32'h7F, 32'h80, 32'h7FF, 32'h800, 32'hD7FF, 32'hD800, 32'hDABC, 32'hDFFF,
                  32'hE000, 32'hFFFF, 32'h10000, 32'h10FFFF, 32'h110000, 32'h1FFFFF,
                  32'h200000, 32'h80000041, 32'hFFFFFFFF, 32'h0};
        // R1: reset held with valid high must leave outputs zero.
        cp_valid_i = 1'b1;
        cp_i = 32'h0000_20AC;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        idle_cycle();
        // R4, R5: every 1- and 2-byte value, back to back (R12).
        for (int v = 0; v < 32'h800; v++) push(32'(v));
        // R6, R10: stride through the 3-byte range including the gap.
        for (int v = 32'h800; v < 32'h10000; v += 89) push(32'(v));
        for (int v = 32'hD7F0; v < 32'hE010; v += 1) push(32'(v));
        // R7: stride through the 4-byte range.
        for (int v = 32'h10000; v <= 32'h10FFFF; v += 2003) push(32'(v));
        // R3, R11: class edges and out-of-range values on consecutive cycles.
        foreach (edges[i]) push(edges[i]);
        for (int k = 21; k < 32; k++) push(32'h41 | (32'h1 << k));
        // R2: a gap produces quiet outputs, then results resume.
        idle_cycle();
        idle_cycle();
        push(32'h1F600);
        idle_cycle();
        push(32'h00E9);
        // R1: reset mid-stream clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        cp_valid_i = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule